// File: doc/BRIEF.md
# Long-Press Reset Pulse Generator

This block turns a sustained press of a reset push-button into one system reset pulse of fixed width. A millisecond tick strobes a hold counter. The counter advances while the active-low button input is low and clears on any tick that finds it high. Once the hold count passes a threshold, the block pulls the system reset line low for a fixed number of ticks. It then drives the line high again.

The reset line is modelled as an open-drain style pad with two outputs: a drive-enable and the level to drive. Out of reset the driver is off. After the first pulse it stays on and holds the line high.

The block re-arms only after the hold count has returned to zero, which means the button must be released. A single long press therefore yields exactly one pulse, however long the button is held. The pulse width does not depend on the hold time.

Top module: `longpress_reset_gen`

## Requirements
- R1: After synchronous reset the block is armed, `rst_level_o` is 1 and `rst_drive_en_o` is 0.
- R2: On each cycle with `tick_i` high, the hold count increments by one if `btn_n_i` is 0, and clears to zero if `btn_n_i` is 1. On cycles without a tick the count is unchanged, whatever the button level.
- R3: The hold count saturates at its all-ones value (2^HOLD_W-1) instead of wrapping to zero. A hold lasting beyond that value therefore never re-arms the block.
- R4: While armed, a hold count greater than HOLD_THRESH (301 ticks with the default of 300) starts a pulse. The cycle after the count reaches that value, `rst_drive_en_o` is 1 and `rst_level_o` is 0. A count of exactly HOLD_THRESH does not start a pulse.
- R5: A pulse lasts exactly PULSE_TICKS ticks. `rst_level_o` returns to 1 on the second cycle after the PULSE_TICKS-th tick following the start of the pulse, whatever the button does meanwhile.
- R6: Once a pulse has started, `rst_drive_en_o` stays 1. While it is 1 and no pulse is in progress, the line is driven high.
- R7: After a pulse, the block returns to armed only when the pulse has ended and the hold count is zero. Holding the button indefinitely yields exactly one pulse.
- R8: After re-arming, a new press longer than HOLD_THRESH ticks produces another full pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe once per millisecond |
| btn_n_i | input | 1 | Raw reset button, low while pressed |
| rst_drive_en_o | output | 1 | Output driver enable for the reset pad |
| rst_level_o | output | 1 | Level driven onto the reset pad when enabled |

## Verification
The assertions assume the following about the inputs:
- `tick_i` and `btn_n_i` are already synchronous to `clk`.
- Reset is held across at least one clock edge before the first check.

Under these assumptions every counter change can be related to the tick that caused it. The stimulus meets them as follows:
- It changes inputs only on falling edges.
- It gives the tick as a single-cycle strobe every four cycles.
- It alters the button level only together with a tick.

With this spacing, the sequencer's reaction to a count always lands between ticks. Press lengths are swept just below and just above the threshold. Further runs cover a hold far past the counter's maximum, a release during the pulse, and a pause with the button high but no tick.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_PULSE   = 2'd1,
        ST_RELEASE = 2'd2
    } lpr_state_e;

    typedef struct packed {
        logic drive_en;
        logic level;
    } pad_t;

    localparam pad_t PAD_OFF  = '{drive_en: 1'b0, level: 1'b1};
    localparam pad_t PAD_LOW  = '{drive_en: 1'b1, level: 1'b0};
    localparam pad_t PAD_HIGH = '{drive_en: 1'b1, level: 1'b1};

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/lpr_hold_counter.sv
module lpr_hold_counter #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         btn_n_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
            if (btn_n_i)
                cnt_d = '0;
            else if (cnt_q != MAX)
                cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !btn_n_i && cnt_q != MAX) |=> (cnt_q == $past(cnt_q) + W'(1)));
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_i && btn_n_i) |=> (cnt_q == '0));
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !btn_n_i && cnt_q == MAX) |=> (cnt_q == MAX));

endmodule

// File: rtl/lpr_pulse_timer.sv
module lpr_pulse_timer #(
    parameter int unsigned W    = 8,
    parameter int unsigned LOAD = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic load_i,
    output logic zero_o
);
    localparam logic [W-1:0] LOAD_V = W'(LOAD);

    logic [W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst)
            tmr_q <= '0;
        else if (load_i)
            tmr_q <= LOAD_V;
        else if (tick_i && tmr_q != '0)
            tmr_q <= tmr_q - W'(1);
    end

    assign zero_o = (tmr_q == '0);

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (tmr_q == LOAD_V));
    assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && tmr_q != '0) |=> (tmr_q == $past(tmr_q) - W'(1)));
    assert_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_i && tmr_q == '0) |=> (tmr_q == '0));

endmodule

// File: rtl/lpr_sequencer.sv
module lpr_sequencer
    import lpr_pkg::*;
#(
    parameter int unsigned HOLD_W = 9,
    parameter int unsigned THRESH = 300
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HOLD_W-1:0] hold_count_i,
    input  logic              timer_zero_i,
    output logic              load_o,
    output pad_t              pad_o
);
    localparam logic [HOLD_W-1:0] THR = HOLD_W'(THRESH);

    lpr_state_e state_q, state_d;
    pad_t       pad_q, pad_d;
    logic       fire;

    assign fire = (state_q == ST_ARMED) && (hold_count_i > THR);

    always_comb begin
        state_d = state_q;
        pad_d   = pad_q;
        case (state_q)
            ST_ARMED: begin
                if (fire) begin
                    state_d = ST_PULSE;
                    pad_d   = PAD_LOW;
                end
            end
            ST_PULSE: begin
                if (timer_zero_i) begin
                    state_d = ST_RELEASE;
                    pad_d   = PAD_HIGH;
                end
            end
            ST_RELEASE: begin
                if (hold_count_i == '0)
                    state_d = ST_ARMED;
            end
            default: begin
                state_d = ST_ARMED;
                pad_d   = PAD_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
            pad_q   <= PAD_OFF;
        end else begin
            state_q <= state_d;
            pad_q   <= pad_d;
        end
    end

    assign load_o = fire;
    assign pad_o  = pad_q;

    assert_fire_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pad_q.level) |-> ($past(hold_count_i) > THR));
    assert_low_driven_R6: assert property (@(posedge clk) disable iff (rst)
        !pad_q.level |-> pad_q.drive_en);
    assert_keep_drive_R6: assert property (@(posedge clk) disable iff (rst)
        $past(pad_q.drive_en) |-> pad_q.drive_en);
    assert_end_on_timer_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_q.level) |-> $past(timer_zero_i));
    assert_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARMED && $past(state_q) == ST_RELEASE) |-> ($past(hold_count_i) == '0));

endmodule

// File: rtl/longpress_reset_gen.sv
module longpress_reset_gen
    import lpr_pkg::*;
#(
    parameter int unsigned HOLD_THRESH = 300,
    parameter int unsigned PULSE_TICKS = 150,
    parameter int unsigned HOLD_W      = bits_for(HOLD_THRESH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic btn_n_i,
    output logic rst_drive_en_o,
    output logic rst_level_o
);
    localparam int unsigned TIMER_W = bits_for(PULSE_TICKS);

    logic [HOLD_W-1:0] hold_count;
    logic              timer_zero;
    logic              load;
    pad_t              pad;

    lpr_hold_counter #(.W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .btn_n_i (btn_n_i),
        .count_o (hold_count)
    );

    lpr_pulse_timer #(.W(TIMER_W), .LOAD(PULSE_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .load_i (load),
        .zero_o (timer_zero)
    );

    lpr_sequencer #(.HOLD_W(HOLD_W), .THRESH(HOLD_THRESH)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .hold_count_i (hold_count),
        .timer_zero_i (timer_zero),
        .load_o       (load),
        .pad_o        (pad)
    );

    assign rst_drive_en_o = pad.drive_en;
    assign rst_level_o    = pad.level;

    assert_pulse_timed_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(!pad.level) && !pad.level) |-> !$past(timer_zero) || $past(load));

endmodule

// File: tb/test_longpress_reset_gen.sv
module test_longpress_reset_gen;
    localparam int THR   = 300;
    localparam int WIDTH = 150;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic btn_n = 1'b1;
    logic drv, lvl;

    int checks = 0, errors = 0;
    int ticks = 0, low_run = 0;
    int falls = 0, rises = 0, fall_run = 0, fall_tick = 0, last_width = 0;
    logic prev_lvl = 1'b1;
    logic mon_on = 1'b0;

    longpress_reset_gen #(.HOLD_THRESH(THR), .PULSE_TICKS(WIDTH)) i_longpress_reset_gen (
        .clk(clk), .rst(rst), .tick_i(tick), .btn_n_i(btn_n),
        .rst_drive_en_o(drv), .rst_level_o(lvl)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_once(input logic b);
        @(negedge clk);
        btn_n = b;
        tick = 1'b1;
        ticks++;
        if (b) low_run = 0; else low_run++;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ticks_n(input int n, input logic b);
        for (int i = 0; i < n; i++) tick_once(b);
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_lvl && !lvl) begin
                falls++;
                fall_run = low_run;
                fall_tick = ticks;
            end
            if (!prev_lvl && lvl) begin
                rises++;
                last_width = ticks - fall_tick;
            end
            if (!lvl && !drv) begin
                errors++;
                $display("FAIL R6 actual=drive_off expected=drive_on while low");
            end
            prev_lvl = lvl;
        end
    end

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 level", lvl, 1);
        check("R1 drive", drv, 0);
        mon_on = 1'b1;

        // R4 sweep of press lengths around the threshold
        for (int len = THR - 3; len <= THR + 3; len++) begin
            f0 = falls;
            ticks_n(len, 1'b0);
            ticks_n(WIDTH + 10, 1'b1);
            check($sformatf("R4 pulses len=%0d", len), falls - f0, (len > THR) ? 1 : 0);
            if (len > THR) begin
                check("R4 start tick", fall_run, THR + 1);
                check("R5 width", last_width, WIDTH);
                check("R6 drive kept", drv, 1);
                check("R6 level high", lvl, 1);
            end
        end

        // R2 clear on high tick: two sub-threshold runs do not add up
        f0 = falls;
        ticks_n(THR, 1'b0);
        ticks_n(1, 1'b1);
        ticks_n(THR, 1'b0);
        ticks_n(2, 1'b1);
        check("R2 clear between runs", falls - f0, 0);

        // R2 no change without tick: button high but no tick
        f0 = falls;
        ticks_n(THR, 1'b0);
        @(negedge clk); btn_n = 1'b1;
        repeat (50) @(negedge clk);
        ticks_n(1, 1'b0);
        ticks_n(WIDTH + 5, 1'b1);
        check("R2 hold without tick", falls - f0, 1);
        check("R5 width after pause", last_width, WIDTH);

        // R5 release during the pulse does not shorten it; R8 re-arm
        f0 = falls;
        ticks_n(THR + 1, 1'b0);
        ticks_n(3, 1'b1);
        check("R5 low during pulse", lvl, 0);
        ticks_n(WIDTH + 5, 1'b1);
        check("R5 width on early release", last_width, WIDTH);
        ticks_n(THR + 1, 1'b0);
        ticks_n(WIDTH + 5, 1'b1);
        check("R8 second press", falls - f0, 2);

        // R3/R7 hold far past counter maximum: single pulse only
        f0 = falls;
        ticks_n(1200, 1'b0);
        check("R7 one pulse long hold", falls - f0, 1);
        check("R3 no wrap rearm", rises - (falls - 1), 1);
        check("R6 level high held", lvl, 1);
        check("R6 drive held", drv, 1);
        ticks_n(2, 1'b1);
        ticks_n(THR + 1, 1'b0);
        ticks_n(WIDTH + 5, 1'b1);
        check("R8 pulse after long hold", falls - f0, 2);
        check("R5 width final", last_width, WIDTH);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule